// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a register-mapped watchdog with an early-warning stage. Software loads a control word that holds an enable bit, a two-bit logarithmic prescale, two 5-bit phase lengths and a reset target. Once enabled, a prescaled tick counter runs the first phase. When that phase ends, the block raises a level interrupt that software can use as a pretimeout notice. The second phase then starts. If the second phase also runs out, the block drives a fixed-length pulse on one of three reset request lines.

Software keeps the system alive by writing the kick word, which puts the timer back at the start of the first phase. After the first phase has expired, the enable bit can no longer stop the timer: only a kick averts the reset. For simulation, the length of the base tick is set as a power of two through a parameter.

The host port is a plain synchronous write strobe with a combinational read. It has a two-bit word index: word 0 is the kick word, word 1 holds the flags, and word 2 holds the control.

Top module: `wdt_twophase`

## Requirements
- R1: After reset the control word reads 0x00000001 (timer disabled, CPU reset target), the flag word reads 0, and the interrupt and all reset lines are low.
- R2: The control word keeps only bit 31 (enable), bits 30:29 (prescale), bits 26:22 (first phase count), bits 19:15 (second phase count) and bits 1:0 (reset target). All other bits read 0. Reads of word 0 and word 3 return 0.
- R3: One tick lasts 2^(TICK_LOG2+prescale) clock cycles. A phase lasts (count+1) ticks. When an enabling write lands at edge W, the first phase expires at edge W+(count1+1)·T.
- R4: When the first phase expires, flag bit 31 of word 1 is set and the interrupt output follows it. The second phase starts from zero at that same edge.
- R5: The second phase expires (count2+1)·T after the first. At that edge flag bit 30 is set and a reset request pulse of RST_LEN cycles begins. The line is chosen by the target field: 0 and 3 select the SoC line, 1 the CPU line, and 2 the software line. At most one line is high at any time.
- R6: When the pulse ends, the enable bit clears. The other control fields and the flags are kept, and the timer stays idle.
- R7: Writing 1 to bit 31 or bit 30 of word 1 clears that flag. Clearing bit 31 drops the interrupt.
- R8: A write to word 0 with bit 31 set restarts the first phase from zero, during either phase. A write with bit 31 clear has no effect. A kick during a reset pulse does not shorten the pulse.
- R9: Clearing the enable bit during the first phase halts the timer and clears its counts. Enabling again starts a full first phase.
- R10: Clearing the enable bit during the second phase does not stop the timer. The reset pulse still arrives on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_word | input | 2 | Word index: 0 kick, 1 flags, 2 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word selected by bus_word |
| irq_o | output | 1 | Pretimeout interrupt, high while the first-phase flag is set |
| soc_rst_o | output | 1 | SoC reset request pulse |
| cpu_rst_o | output | 1 | CPU reset request pulse |
| sw_rst_o | output | 1 | Software reset request pulse |

## Verification
The hardest situations to reach are the ones that act on the timer while it is in its second phase: a kick that pulls it back to the first phase, and a disable that must be ignored. The second phase is only a few ticks long, so these writes have to land at exact cycles. The bench runs with a small tick length and computes every expiry edge from the edge of the enabling write. It then places the kick or the disable write a known number of cycles after the interrupt rises. The scoreboard holds the expected cycle of each interrupt rise and each reset rise, so an event that comes early, late or on the wrong line is reported.

// File: rtl/wdt_twophase.sv
module wdt_twophase #(
  parameter int TICK_LOG2 = 25,
  parameter int RST_LEN   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        soc_rst_o,
  output logic        cpu_rst_o,
  output logic        sw_rst_o
);
  localparam int PW = TICK_LOG2 + 3;
  localparam int RW = $clog2(RST_LEN + 1);
  localparam logic [31:0] CTRL_MASK = 32'hE7CF_8003;

  typedef enum logic [1:0] {PH1, PH2, PHR} phase_t;

  phase_t          phase;
  logic [31:0]     ctrl;
  logic            flag_p1, flag_p2;
  logic [PW-1:0]   presc;
  logic [4:0]      tcnt;
  logic [RW-1:0]   rcnt;
  logic [1:0]      rsel;

  wire       en    = ctrl[31];
  wire [1:0] ps    = ctrl[30:29];
  wire [4:0] f1    = ctrl[26:22];
  wire [4:0] f2    = ctrl[19:15];
  wire [1:0] mode  = ctrl[1:0];

  wire wr_kick = bus_we && bus_word == 2'd0 && bus_wdata[31];
  wire wr_flag = bus_we && bus_word == 2'd1;
  wire wr_ctrl = bus_we && bus_word == 2'd2;

  logic [PW-1:0] lim;
  assign lim = ~({PW{1'b1}} << (TICK_LOG2 + 32'(ps)));

  wire counting = (phase == PH1 && en) || phase == PH2;
  wire tick     = counting && presc == lim;
  wire expire   = tick && tcnt == ((phase == PH1) ? f1 : f2);
  wire rst_any  = phase == PHR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= 32'h0000_0001;
      flag_p1 <= 1'b0;
      flag_p2 <= 1'b0;
      presc   <= '0;
      tcnt    <= '0;
      rcnt    <= '0;
      rsel    <= '0;
      phase   <= PH1;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata & CTRL_MASK;
      if (wr_flag) begin
        if (bus_wdata[31]) flag_p1 <= 1'b0;
        if (bus_wdata[30]) flag_p2 <= 1'b0;
      end
      case (phase)
        PH1, PH2: begin
          if (wr_kick || (phase == PH1 && !en)) begin
            presc <= '0;
            tcnt  <= '0;
            phase <= PH1;
          end else if (tick) begin
            presc <= '0;
            if (expire) begin
              tcnt <= '0;
              if (phase == PH1) begin
                phase   <= PH2;
                flag_p1 <= 1'b1;
              end else begin
                phase   <= PHR;
                flag_p2 <= 1'b1;
                rsel    <= mode;
                rcnt    <= '0;
              end
            end else begin
              tcnt <= tcnt + 5'd1;
            end
          end else begin
            presc <= presc + PW'(1);
          end
        end
        PHR: begin
          if (rcnt == RW'(RST_LEN - 1)) begin
            rcnt     <= '0;
            phase    <= PH1;
            ctrl[31] <= 1'b0;
          end else begin
            rcnt <= rcnt + RW'(1);
          end
        end
        default: phase <= PH1;
      endcase
    end
  end

  assign irq_o     = flag_p1;
  assign soc_rst_o = rst_any && (rsel == 2'd0 || rsel == 2'd3);
  assign cpu_rst_o = rst_any && rsel == 2'd1;
  assign sw_rst_o  = rst_any && rsel == 2'd2;

  always_comb begin
    case (bus_word)
      2'd1:    bus_rdata = {flag_p1, flag_p2, 30'b0};
      2'd2:    bus_rdata = ctrl;
      default: bus_rdata = 32'b0;
    endcase
  end

  AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({soc_rst_o, cpu_rst_o, sw_rst_o})); // R5
  AST_RST_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soc_rst_o | cpu_rst_o | sw_rst_o) |-> flag_p2); // R5
  AST_PULSE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soc_rst_o | cpu_rst_o | sw_rst_o) |-> !ctrl[31]); // R6
  AST_KICK_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kick && phase != PHR) |=> !(soc_rst_o | cpu_rst_o | sw_rst_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH1 && !en) |=> !$rose(irq_o)); // R9
  AST_PH2_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH2 && !wr_kick) |=> phase != PH1); // R10
endmodule

// File: tb/wdt_twophase_bench.sv
module wdt_twophase_bench;
  localparam int TL = 2;
  localparam int RL = 16;
  localparam int LIMIT = 20000;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  wire [31:0] rdata;
  wire irq, soc, cpu, sw;
  int cyc = 0, checks = 0, errors = 0;
  int q_kind[$];
  int q_cyc[$];
  string q_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_twophase #(.TICK_LOG2(TL), .RST_LEN(RL)) u_wdt_twophase (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_word(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_o(irq), .soc_rst_o(soc), .cpu_rst_o(cpu), .sw_rst_o(sw));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kinds: 1 irq rise, 2 soc, 3 cpu, 4 sw
  task automatic expect_evt(input int kind, input int c, input string tag);
    q_kind.push_back(kind); q_cyc.push_back(c); q_tag.push_back(tag);
  endtask

  task automatic pop_cmp(input int kind);
    if (q_kind.size() == 0) begin
      check(1'b0, "R5", kind * 100000 + cyc, 0);
    end else begin
      int k = q_kind.pop_front();
      int c = q_cyc.pop_front();
      string t = q_tag.pop_front();
      check(k == kind && c == cyc, t, kind * 100000 + cyc, k * 100000 + c);
    end
  endtask

  logic p_irq = 1'b0, p_soc = 1'b0, p_cpu = 1'b0, p_sw = 1'b0;
  int wid = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && !p_irq) pop_cmp(1);
      if (soc && !p_soc) pop_cmp(2);
      if (cpu && !p_cpu) pop_cmp(3);
      if (sw && !p_sw) pop_cmp(4);
      if (soc | cpu | sw) wid++;
      else if (wid != 0) begin
        check(wid == RL, "R5", wid, RL);
        wid = 0;
      end
      p_irq = irq; p_soc = soc; p_cpu = cpu; p_sw = sw;
    end
  end

  function automatic logic [31:0] ctl(input bit e, input int p, input int c1, input int c2, input int m);
    return {e, 2'(p), 2'b0, 5'(c1), 2'b0, 5'(c2), 13'b0, 2'(m)};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int e);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; e = cyc;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d", LIMIT, 0);
    summary();
    $finish;
  end

  initial begin
    int w, k, k2, dummy;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(2'd2, v); check(v == 32'h1, "R1", v, 32'h1);
    rd(2'd1, v); check(v == 32'h0, "R1", v, 0);
    check({irq, soc, cpu, sw} == 4'b0, "R1", {irq, soc, cpu, sw}, 0);
    // R2
    rd(2'd0, v); check(v == 32'h0, "R2", v, 0);
    rd(2'd3, v); check(v == 32'h0, "R2", v, 0);
    wr(2'd2, 32'h7FFF_FFFC, dummy);
    rd(2'd2, v); check(v == 32'h67CF_8000, "R2", v, 32'h67CF_8000);
    wr(2'd2, ctl(0, 0, 0, 0, 1), dummy);

    // A: R3/R4/R5 cpu target, R6 enable cleared
    wr(2'd2, ctl(1, 0, 2, 1, 1), w);
    expect_evt(1, w + 12, "R3"); expect_evt(3, w + 20, "R5");
    wait_to(w + 20 + RL + 3);
    check(q_kind.size() == 0, "R5", q_kind.size(), 0);
    rd(2'd2, v); check(v == ctl(0, 0, 2, 1, 1), "R6", v, ctl(0, 0, 2, 1, 1));
    rd(2'd1, v); check(v == 32'hC000_0000, "R4", v, 32'hC000_0000);
    // R7
    wr(2'd1, 32'h8000_0000, dummy);
    rd(2'd1, v); check(v == 32'h4000_0000, "R7", v, 32'h4000_0000);
    check(irq == 1'b0, "R7", irq, 0);
    wr(2'd1, 32'h4000_0000, dummy);
    rd(2'd1, v); check(v == 32'h0, "R7", v, 0);

    // B: prescale 1, soc target (R3, R5)
    wr(2'd2, ctl(1, 1, 0, 0, 0), w);
    expect_evt(1, w + 8, "R3"); expect_evt(2, w + 16, "R5");
    wait_to(w + 16 + RL + 3);
    wr(2'd1, 32'hC000_0000, dummy);

    // C: target 3 behaves as soc (R5)
    wr(2'd2, ctl(1, 0, 0, 3, 3), w);
    expect_evt(1, w + 4, "R4"); expect_evt(2, w + 20, "R5");
    wait_to(w + 20 + RL + 3);
    wr(2'd1, 32'hC000_0000, dummy);

    // D: disable during second phase ignored, sw target (R10)
    wr(2'd2, ctl(1, 0, 1, 4, 2), w);
    expect_evt(1, w + 8, "R4"); expect_evt(4, w + 28, "R10");
    wait_to(w + 9);
    wr(2'd2, ctl(0, 0, 1, 4, 2), dummy);
    wait_to(w + 28 + RL + 3);
    check(q_kind.size() == 0, "R10", q_kind.size(), 0);
    wr(2'd1, 32'hC000_0000, dummy);

    // E: disable in first phase halts and clears (R9)
    wr(2'd2, ctl(1, 0, 3, 0, 1), w);
    wait_to(w + 4);
    wr(2'd2, ctl(0, 0, 3, 0, 1), dummy);
    wait_to(w + 60);
    check(irq == 1'b0, "R9", irq, 0);
    rd(2'd1, v); check(v == 32'h0, "R9", v, 0);
    wr(2'd2, ctl(1, 0, 3, 0, 1), w);
    expect_evt(1, w + 16, "R9"); expect_evt(3, w + 20, "R9");
    wait_to(w + 20 + RL + 3);
    wr(2'd1, 32'hC000_0000, dummy);

    // F: kicks in both phases, ignored kick data, kick during pulse (R8)
    wr(2'd2, ctl(1, 0, 3, 0, 1), w);
    wait_to(w + 3);
    wr(2'd0, 32'h7FFF_FFFF, dummy);
    wait_to(w + 9);
    wr(2'd0, 32'h8000_0000, k);
    expect_evt(1, k + 16, "R8");
    wait_to(k + 17);
    wr(2'd0, 32'h8000_0000, k2);
    wr(2'd1, 32'h8000_0000, dummy);
    expect_evt(1, k2 + 16, "R8"); expect_evt(3, k2 + 20, "R8");
    wait_to(k2 + 24);
    wr(2'd0, 32'h8000_0000, dummy);
    wait_to(k2 + 20 + RL + 3);
    check(q_kind.size() == 0, "R8", q_kind.size(), 0);
    rd(2'd1, v); check(v == 32'hC000_0000, "R5", v, 32'hC000_0000);

    summary();
    $finish;
  end
endmodule